// File: doc/BRIEF.md
# Shared receiver collision detector

This block sits at the receive end of one serial optical lane that several transmitters drive with no arbiter to grant access. Transmitters launch packets only at slot boundaries. When two of them pick the same slot, the receiver sees a corrupted packet. Each beat brings one lane-width slice of the packet together with a signal-integrity flag. At the end of the packet the block sorts the slot into one of three outcomes:

- an idle slot;
- a clean packet;
- a collision.

Bit errors and collisions take the same path: both make the slot unusable.

A clean packet is written into a one-packet output buffer and handed to the local consumer as 72-bit flits under valid/ready flow control. A fixed number of cycles after the packet ends, the block drives a one-cycle pulse on the 1-bit confirmation lane, tagged with the sender ID taken from the header. That lane never collides. A sender that sees no confirmation assumes its packet was lost and retransmits. For this reason the block only confirms a packet that it has actually stored.

Top module: `shared_lane_rx`

## Requirements
- R1: After reset, conf_o, coll_o, out_valid_o and out_last_o are all low.
- R2: Framing rules:
  - A packet starts only on a cycle where slot_start_i and lane_vld_i are both high while no packet is in progress.
  - A packet then occupies exactly PKT_FLITS*72/LANE_W consecutive cycles. Beat k carries packet bits [k*LANE_W +: LANE_W], so the first beat holds the least significant bits.
  - lane_vld_i high without slot_start_i while idle is ignored.
  - slot_start_i with lane_vld_i low is an idle slot and produces no output.
- R3: The header carries the sender ID in packet bits [SID_W-1:0] and an even-parity bit in bit [SID_W]. The XOR of bits [SID_W:0] must be 0. A packet is clean only if all three of these hold:
  - the parity check passes;
  - corrupt_i is low on every beat;
  - lane_vld_i is high on every beat.
- R4: For a clean packet that is stored, conf_o is high for exactly one cycle: the CONF_DLY-th cycle after the cycle of the last beat. In that cycle conf_id_o equals the header sender ID.
- R5: For a packet that is not clean, coll_o is high for exactly the one cycle after the last beat. No confirmation is sent and no flit is emitted.
- R6: Output timing and order:
  - out_valid_o rises in the cycle after the last beat of a stored packet.
  - Flit k equals packet bits [k*72 +: 72], for k from 0 to PKT_FLITS-1.
  - out_last_o marks the final flit.
  - out_valid_o falls after the final flit's handshake.
- R7: While out_ready_i is low, out_valid_o and out_flit_o hold their values and no flit is lost.
- R8: A clean packet that completes while the buffer still holds an earlier packet is neither stored nor confirmed, and coll_o stays low. The buffered packet is delivered unchanged.
- R9: corrupt_i asserted while no packet is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_start_i | input | 1 | First beat of a time slot |
| lane_vld_i | input | 1 | Light detected on the lane this beat |
| lane_data_i | input | LANE_W | Lane slice for this beat |
| corrupt_i | input | 1 | Signal-integrity failure on this beat |
| conf_o | output | 1 | Confirmation pulse |
| conf_id_o | output | SID_W | Sender being confirmed |
| coll_o | output | 1 | Collision or error detected on the slot just ended |
| out_valid_o | output | 1 | Flit available |
| out_ready_i | input | 1 | Consumer accepts flit |
| out_flit_o | output | 72 | Flit data |
| out_last_o | output | 1 | Final flit of the packet |

## Verification
The assertions take it as given that slot boundaries line up with packet length. In other words, slot_start_i never arrives while a packet is still being received. They also take it that a packet spans at least two beats, so confirmations can never be back to back. The stimulus meets both conditions: every slot_start_i falls on an idle receiver, and several idle cycles separate one packet from the next. Collisions are modelled by raising corrupt_i on a chosen beat, by dropping lane_vld_i partway through a packet, or by breaking the header parity.

// File: rtl/shared_lane_rx_pkg.sv
package shared_lane_rx_pkg;
  localparam int unsigned FLIT_W = 72;
  typedef enum logic [1:0] {SLOT_NONE, SLOT_CLEAN, SLOT_BAD} slot_res_e;
endpackage

// File: rtl/lane_deser.sv
module lane_deser
  import shared_lane_rx_pkg::*;
#(
  parameter int unsigned LANE_W    = 6,
  parameter int unsigned PKT_FLITS = 5,
  parameter int unsigned SID_W     = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        slot_start_i,
  input  logic                        lane_vld_i,
  input  logic [LANE_W-1:0]           lane_data_i,
  input  logic                        corrupt_i,
  input  logic                        buf_full_i,
  output logic                        load_o,
  output logic [PKT_FLITS*FLIT_W-1:0] pkt_o,
  output logic [SID_W-1:0]            sid_o,
  output logic                        coll_o
);
  localparam int unsigned TOT_W = PKT_FLITS * FLIT_W;
  localparam int unsigned BEATS = TOT_W / LANE_W;
  localparam int unsigned CNT_W = $clog2(BEATS + 1);

  logic              busy_q, bad_q, coll_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [TOT_W-1:0]  asm_q, asm_d;
  logic              start, beat, last, bad_acc, hdr_ok;
  slot_res_e         res;

  assign start   = !busy_q && slot_start_i && lane_vld_i;
  assign beat    = start || busy_q;
  assign last    = beat && (start ? (BEATS == 1) : (cnt_q == CNT_W'(BEATS - 1)));
  assign bad_acc = (busy_q && bad_q) || corrupt_i || !lane_vld_i;
  // LSB-first: newest slice enters at the top
  assign asm_d   = {lane_data_i, asm_q[TOT_W-1:LANE_W]};
  assign hdr_ok  = ~^asm_d[SID_W:0];

  always_comb begin
    res = SLOT_NONE;
    if (last) res = (bad_acc || !hdr_ok) ? SLOT_BAD : SLOT_CLEAN;
  end

  assign load_o = (res == SLOT_CLEAN) && !buf_full_i;
  assign pkt_o  = asm_d;
  assign sid_o  = asm_d[SID_W-1:0];
  assign coll_o = coll_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      bad_q  <= 1'b0;
      coll_q <= 1'b0;
      cnt_q  <= '0;
      asm_q  <= '0;
    end else begin
      coll_q <= (res == SLOT_BAD);
      if (beat) begin
        asm_q <= asm_d;
        bad_q <= bad_acc;
        if (last) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          busy_q <= 1'b1;
          cnt_q  <= start ? CNT_W'(1) : cnt_q + CNT_W'(1);
        end
      end
    end
  end

  // R2 input assumption: slots align with packet length
  a_r2_slot_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !slot_start_i);
endmodule

// File: rtl/conf_pipe.sv
module conf_pipe #(
  parameter int unsigned SID_W = 4,
  parameter int unsigned DLY   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [SID_W-1:0] id_i,
  output logic             conf_o,
  output logic [SID_W-1:0] id_o
);
  logic [DLY-1:0]   v_q;
  logic [SID_W-1:0] id_q [DLY];

  for (genvar k = 0; k < DLY; k++) begin : g_stage
    logic             v_in;
    logic [SID_W-1:0] id_in;
    if (k == 0) begin : g_head
      assign v_in  = fire_i;
      assign id_in = id_i;
    end else begin : g_tail
      assign v_in  = v_q[k-1];
      assign id_in = id_q[k-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[k]  <= 1'b0;
        id_q[k] <= '0;
      end else begin
        v_q[k]  <= v_in;
        id_q[k] <= id_in;
      end
    end
  end

  assign conf_o = v_q[DLY-1];
  assign id_o   = id_q[DLY-1];
endmodule

// File: rtl/pkt_buf.sv
module pkt_buf
  import shared_lane_rx_pkg::*;
#(
  parameter int unsigned PKT_FLITS = 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [PKT_FLITS*FLIT_W-1:0] pkt_i,
  input  logic                        ready_i,
  output logic                        valid_o,
  output logic [FLIT_W-1:0]           flit_o,
  output logic                        last_o,
  output logic                        full_o
);
  localparam int unsigned TOT_W = PKT_FLITS * FLIT_W;
  localparam int unsigned IDX_W = (PKT_FLITS > 1) ? $clog2(PKT_FLITS) : 1;

  logic             full_q;
  logic [TOT_W-1:0] pkt_q;
  logic [IDX_W-1:0] idx_q;
  logic             hs;

  assign hs      = full_q && ready_i;
  assign valid_o = full_q;
  assign full_o  = full_q;

  if (PKT_FLITS > 1) begin : g_multi
    assign flit_o = pkt_q[idx_q*FLIT_W +: FLIT_W];
    assign last_o = full_q && (idx_q == IDX_W'(PKT_FLITS - 1));
  end else begin : g_single
    assign flit_o = pkt_q[FLIT_W-1:0];
    assign last_o = full_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      pkt_q  <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      full_q <= 1'b1;
      pkt_q  <= pkt_i;
      idx_q  <= '0;
    end else if (hs) begin
      if (last_o) begin
        full_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  a_r8_load_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !full_q);
  a_r7_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(flit_o)));
  a_r6_last_drains: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && last_o) |=> !valid_o);
endmodule

// File: rtl/shared_lane_rx.sv
module shared_lane_rx
  import shared_lane_rx_pkg::*;
#(
  parameter int unsigned LANE_W    = 6,
  parameter int unsigned PKT_FLITS = 5,
  parameter int unsigned SID_W     = 4,
  parameter int unsigned CONF_DLY  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_start_i,
  input  logic              lane_vld_i,
  input  logic [LANE_W-1:0] lane_data_i,
  input  logic              corrupt_i,
  output logic              conf_o,
  output logic [SID_W-1:0]  conf_id_o,
  output logic              coll_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [71:0]       out_flit_o,
  output logic              out_last_o
);
  localparam int unsigned TOT_W = PKT_FLITS * FLIT_W;

  logic             load, buf_full;
  logic [TOT_W-1:0] pkt;
  logic [SID_W-1:0] sid;

  lane_deser #(.LANE_W(LANE_W), .PKT_FLITS(PKT_FLITS), .SID_W(SID_W)) u_deser (
    .clk_i, .rst_ni, .slot_start_i, .lane_vld_i, .lane_data_i, .corrupt_i,
    .buf_full_i(buf_full), .load_o(load), .pkt_o(pkt), .sid_o(sid), .coll_o(coll_o)
  );

  conf_pipe #(.SID_W(SID_W), .DLY(CONF_DLY)) u_conf (
    .clk_i, .rst_ni, .fire_i(load), .id_i(sid), .conf_o(conf_o), .id_o(conf_id_o)
  );

  pkt_buf #(.PKT_FLITS(PKT_FLITS)) u_buf (
    .clk_i, .rst_ni, .load_i(load), .pkt_i(pkt), .ready_i(out_ready_i),
    .valid_o(out_valid_o), .flit_o(out_flit_o), .last_o(out_last_o), .full_o(buf_full)
  );

  a_r4_conf_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conf_o |=> !conf_o);
  a_r5_coll_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_o |=> !coll_o);
endmodule

// File: tb/shared_lane_rx_tb_top.sv
module shared_lane_rx_tb_top;
  localparam int LANE_W = 6, PKT_FLITS = 5, SID_W = 4;
  localparam int TOT = PKT_FLITS * 72, BEATS = TOT / LANE_W;

  logic clk = 0, rst_n = 0;
  logic slot_start = 0, lane_vld = 0, corrupt = 0, out_ready = 0;
  logic [LANE_W-1:0] lane_data = '0;
  logic conf, coll, out_valid, out_last;
  logic [SID_W-1:0] conf_id;
  logic [71:0] out_flit;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  shared_lane_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .slot_start_i(slot_start), .lane_vld_i(lane_vld),
    .lane_data_i(lane_data), .corrupt_i(corrupt), .conf_o(conf), .conf_id_o(conf_id),
    .coll_o(coll), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_flit_o(out_flit), .out_last_o(out_last)
  );

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [TOT-1:0] make_pkt(input logic [3:0] sid, input logic badpar,
                                               input logic [7:0] seed);
    logic [TOT-1:0] p;
    for (int i = 0; i < TOT / 8; i++) p[i*8 +: 8] = seed + 8'(i * 37);
    p[3:0] = sid;
    p[4]   = (^sid) ^ badpar;
    return p;
  endfunction

  // cbeat/gap = 63 means none
  task automatic send(input logic [TOT-1:0] p, input int cbeat, input int gap,
                      input bit use_slot);
    for (int b = 0; b < BEATS; b++) begin
      @(negedge clk);
      slot_start = use_slot && (b == 0);
      lane_vld   = (b != gap);
      corrupt    = (b == cbeat);
      lane_data  = p[b*LANE_W +: LANE_W];
    end
  endtask

  task automatic idle_drive();
    slot_start = 0; lane_vld = 0; corrupt = 0; lane_data = '0;
  endtask

  task automatic result(input string tag, input bit exp_conf, input bit exp_coll,
                        input logic [3:0] sid);
    @(negedge clk); idle_drive();
    chk({tag, " R5 coll"}, 72'(coll), 72'(exp_coll));
    chk({tag, " R4 conf early"}, 72'(conf), 72'(0));
    @(negedge clk);
    chk({tag, " R4 conf"}, 72'(conf), 72'(exp_conf));
    if (exp_conf) chk({tag, " R4 conf_id"}, 72'(conf_id), 72'(sid));
    @(negedge clk);
    chk({tag, " R4 conf width"}, 72'(conf), 72'(0));
    chk({tag, " R5 coll width"}, 72'(coll), 72'(0));
  endtask

  task automatic drain(input string tag, input logic [TOT-1:0] p);
    for (int k = 0; k < PKT_FLITS; k++) begin
      chk({tag, " R6 valid"}, 72'(out_valid), 72'(1));
      chk({tag, " R6 flit"}, out_flit, p[k*72 +: 72]);
      chk({tag, " R6 last"}, 72'(out_last), 72'(k == PKT_FLITS - 1));
      out_ready = 1;
      @(negedge clk);
    end
    out_ready = 0;
    chk({tag, " R6 empty"}, 72'(out_valid), 72'(0));
  endtask

  // {sid, cbeat, badpar, gap, seed, exp_conf, exp_coll}
  localparam logic [26:0] VEC [8] = '{
    {4'd3,  6'd63, 1'b0, 6'd63, 8'h11, 1'b1, 1'b0},
    {4'd12, 6'd63, 1'b0, 6'd63, 8'hA5, 1'b1, 1'b0},
    {4'd7,  6'd0,  1'b0, 6'd63, 8'h3C, 1'b0, 1'b1},
    {4'd9,  6'd59, 1'b0, 6'd63, 8'h5A, 1'b0, 1'b1},
    {4'd1,  6'd63, 1'b1, 6'd63, 8'h77, 1'b0, 1'b1},
    {4'd15, 6'd63, 1'b0, 6'd30, 8'h02, 1'b0, 1'b1},
    {4'd0,  6'd63, 1'b0, 6'd63, 8'hFF, 1'b1, 1'b0},
    {4'd6,  6'd25, 1'b0, 6'd63, 8'h40, 1'b0, 1'b1}
  };

  initial begin
    logic [TOT-1:0] pa, pb;
    repeat (3) @(negedge clk);
    chk("R1 conf", 72'(conf), 72'(0));
    chk("R1 coll", 72'(coll), 72'(0));
    chk("R1 valid", 72'(out_valid), 72'(0));
    chk("R1 last", 72'(out_last), 72'(0));
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      logic [26:0] e;
      e  = VEC[v];
      pa = make_pkt(e[26:23], e[16], e[9:2]);
      send(pa, int'(e[22:17]), int'(e[15:10]), 1);
      result("vec R3", e[1], e[0], e[26:23]);
      if (e[1]) drain("vec", pa);
      else chk("vec R5 nothing out", 72'(out_valid), 72'(0));
      repeat (2) @(negedge clk);
    end

    // R2 idle slot
    @(negedge clk); slot_start = 1; lane_vld = 0;
    @(negedge clk); idle_drive();
    repeat (BEATS) @(negedge clk);
    chk("R2 idle slot coll", 72'(coll), 72'(0));
    chk("R2 idle slot valid", 72'(out_valid), 72'(0));

    // R2 lane_vld without slot start ignored, R9 stray corrupt
    pa = make_pkt(4'd5, 0, 8'h21);
    send(pa, 63, 63, 0);
    @(negedge clk); idle_drive(); corrupt = 1;
    repeat (3) @(negedge clk); corrupt = 0;
    chk("R2 unslotted no output", 72'(out_valid), 72'(0));
    chk("R2 unslotted no conf", 72'(conf), 72'(0));
    chk("R9 stray corrupt coll", 72'(coll), 72'(0));
    pa = make_pkt(4'd10, 0, 8'h66);
    send(pa, 63, 63, 1);
    result("R9 clean after stray", 1, 0, 4'd10);
    drain("R9", pa);

    // R7 stall, R8 buffer full
    pa = make_pkt(4'd2, 0, 8'h90);
    pb = make_pkt(4'd11, 0, 8'h13);
    send(pa, 63, 63, 1);
    result("R7 first", 1, 0, 4'd2);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R7 held valid", 72'(out_valid), 72'(1));
      chk("R7 held flit", out_flit, pa[71:0]);
    end
    send(pb, 63, 63, 1);
    result("R8 full", 0, 0, 4'd11);
    drain("R8 buffered intact", pa);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1..R9 actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule